// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is the capture stage on a memory-module command and address path. On every rising clock edge it samples a data word and three control bits (chip select, on-die termination, clock enable) and presents them on registered outputs. Two active-low chip-select inputs jointly decide whether the data outputs may change: when both are high the data outputs hold their value, while the three control outputs are always refreshed.

A configuration input selects the width mode. In wide mode the full data word passes one-to-one to the A bank and the B bank stays low. In dual mode only a half-width subset of the input is captured, and each captured bit drives both an A output and a B output; a second configuration input picks which half of the input positions supplies that subset. An asynchronous active-low reset clears every register and forces every output low, overriding the chip-select gating. The configuration inputs are static and change only while reset is held.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: In wide mode (cfg_dual=0), with at least one chip-select input low at a rising edge, q_a equals d_in as sampled at that edge, from that edge until the next.
- R2: When cs_a_n and cs_b_n are both high at a rising edge, q_a and q_b keep the values they held before that edge.
- R3: Each of the three chip-select patterns 0/0, 0/1 and 1/0 on cs_a_n/cs_b_n lets the data outputs take the newly sampled data.
- R4: cs_q_a, odt_q_a and cke_q_a follow cs_a_n, ctl_odt and ctl_cke as sampled at each rising edge, whatever the chip-select state.
- R5: While rst_n is low every output is low, taking effect without a clock edge and regardless of the chip-select inputs.
- R6: In dual mode (cfg_dual=1), q_b, cs_q_b, odt_q_b and cke_q_b carry the same values as q_a[NW-1:0], cs_q_a, odt_q_a and cke_q_a.
- R7: In dual mode, cfg_hi=0 captures d_in[NW-1:0] and cfg_hi=1 captures d_in[DW-1:DW-NW] into q_a[NW-1:0]; q_a[DW-1:NW] stays low.
- R8: In wide mode the B bank (q_b, cs_q_b, odt_q_b, cke_q_b) is low.
- R9: After reset is released with all data and control inputs low, every output stays low on the following clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | 0: wide one-to-one mode, 1: half-width duplicated mode |
| cfg_hi | input | 1 | Dual mode input subset: 0 lower half, 1 upper half |
| cs_a_n | input | 1 | Chip select, active low; also registered to cs_q_a |
| cs_b_n | input | 1 | Second chip select, active low; gating only |
| ctl_odt | input | 1 | Termination control bit, never gated |
| ctl_cke | input | 1 | Clock-enable control bit, never gated |
| d_in | input | DW | Data word |
| q_a | output | DW | A bank data outputs |
| q_b | output | NW | B bank data outputs |
| cs_q_a | output | 1 | Registered chip select, A bank |
| cs_q_b | output | 1 | Registered chip select, B bank |
| odt_q_a | output | 1 | Registered termination bit, A bank |
| odt_q_b | output | 1 | Registered termination bit, B bank |
| cke_q_a | output | 1 | Registered clock-enable bit, A bank |
| cke_q_b | output | 1 | Registered clock-enable bit, B bank |

## Verification
The data word is driven with walking ones, alternating bit patterns and all ones, under each of the four chip-select combinations, so a stuck, swapped or misrouted bit and a wrong gating polarity each give a distinct mismatch. Runs with both selects high while data and control bits toggle separate the frozen data path from the always-refreshed control path. Dual mode is exercised with patterns that differ between the lower and upper input halves, which exposes a wrong subset choice, a missing duplicate on the B bank, or leakage into the upper A outputs. Reset is applied asynchronously mid-cycle with the selects high to show its priority, and released with zero inputs to show the outputs stay low.

// File: rtl/cs_gated_cmd_reg.sv
module cs_gated_cmd_reg #(
  parameter int DW = 22,
  parameter int NW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dual,
  input  logic          cfg_hi,
  input  logic          cs_a_n,
  input  logic          cs_b_n,
  input  logic          ctl_odt,
  input  logic          ctl_cke,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] q_a,
  output logic [NW-1:0] q_b,
  output logic          cs_q_a,
  output logic          cs_q_b,
  output logic          odt_q_a,
  output logic          odt_q_b,
  output logic          cke_q_a,
  output logic          cke_q_b
);
  localparam int PW = DW - NW;

  logic [DW-1:0] data_r;
  logic [NW-1:0] half_sel;
  logic [DW-1:0] capt;
  logic          freeze;
  logic          cs_r, odt_r, cke_r;

  assign freeze   = cs_a_n & cs_b_n;
  assign half_sel = cfg_hi ? d_in[DW-1 -: NW] : d_in[NW-1:0];
  assign capt     = cfg_dual ? {{PW{1'b0}}, half_sel} : d_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_r <= '0;
      cs_r   <= 1'b0;
      odt_r  <= 1'b0;
      cke_r  <= 1'b0;
    end else begin
      if (!freeze) data_r <= capt;
      cs_r  <= cs_a_n;
      odt_r <= ctl_odt;
      cke_r <= ctl_cke;
    end
  end

  assign q_a     = data_r;
  assign cs_q_a  = cs_r;
  assign odt_q_a = odt_r;
  assign cke_q_a = cke_r;

  assign q_b     = cfg_dual ? data_r[NW-1:0] : '0;
  assign cs_q_b  = cfg_dual & cs_r;
  assign odt_q_b = cfg_dual & odt_r;
  assign cke_q_b = cfg_dual & cke_r;
endmodule

// File: rtl/cs_gated_cmd_reg_chk.sv
module cs_gated_cmd_reg_chk #(
  parameter int DW = 22,
  parameter int NW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_dual,
  input logic          cfg_hi,
  input logic          cs_a_n,
  input logic          cs_b_n,
  input logic          ctl_odt,
  input logic          ctl_cke,
  input logic [DW-1:0] d_in,
  input logic [DW-1:0] q_a,
  input logic [NW-1:0] q_b,
  input logic          cs_q_a,
  input logic          cs_q_b,
  input logic          odt_q_a,
  input logic          odt_q_b,
  input logic          cke_q_a,
  input logic          cke_q_b
);
  AST_WIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dual && !(cs_a_n && cs_b_n)) |=> (q_a == $past(d_in))); // R1
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a_n && cs_b_n) |=> ($stable(q_a) && $stable(q_b))); // R2
  AST_CTRL_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_q_a == $past(cs_a_n) && odt_q_a == $past(ctl_odt) && cke_q_a == $past(ctl_cke))); // R4
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> (q_a == '0 && q_b == '0 && !cs_q_a && !cs_q_b && !odt_q_a && !odt_q_b && !cke_q_a && !cke_q_b)); // R5
  AST_DUAL_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dual |-> (q_b == q_a[NW-1:0] && cs_q_b == cs_q_a && odt_q_b == odt_q_a && cke_q_b == cke_q_a)); // R6
  AST_DUAL_UPPER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dual |-> (q_a[DW-1:NW] == '0)); // R7
  AST_DUAL_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dual && !(cs_a_n && cs_b_n)) |=>
      (q_a[NW-1:0] == ($past(cfg_hi) ? $past(d_in[DW-1 -: NW]) : $past(d_in[NW-1:0])))); // R7
  AST_WIDE_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dual |-> (q_b == '0 && !cs_q_b && !odt_q_b && !cke_q_b)); // R8
endmodule

bind cs_gated_cmd_reg cs_gated_cmd_reg_chk #(.DW(DW), .NW(NW)) u_chk (.*);

// File: tb/cs_gated_cmd_reg_tb_top.sv
module cs_gated_cmd_reg_tb_top;
  localparam int DW = 22;
  localparam int NW = 11;
  localparam int VW = DW + NW + 6;

  typedef struct {
    int          due;
    logic [VW-1:0] v;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dual = 1'b0, cfg_hi = 1'b0;
  logic cs_a_n = 1'b0, cs_b_n = 1'b0, ctl_odt = 1'b0, ctl_cke = 1'b0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q_a;
  logic [NW-1:0] q_b;
  logic cs_q_a, cs_q_b, odt_q_a, odt_q_b, cke_q_a, cke_q_b;

  int cyc = 0, checks = 0, errors = 0;
  exp_t sb[$];
  logic [DW-1:0] m_data = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cs_gated_cmd_reg #(.DW(DW), .NW(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_hi(cfg_hi),
    .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .ctl_odt(ctl_odt), .ctl_cke(ctl_cke),
    .d_in(d_in), .q_a(q_a), .q_b(q_b), .cs_q_a(cs_q_a), .cs_q_b(cs_q_b),
    .odt_q_a(odt_q_a), .odt_q_b(odt_q_b), .cke_q_a(cke_q_a), .cke_q_b(cke_q_b));

  function automatic logic [VW-1:0] outs();
    return {q_a, q_b, cs_q_a, cs_q_b, odt_q_a, odt_q_b, cke_q_a, cke_q_b};
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic ca, input logic cb,
                      input logic odt, input logic cke, input logic [DW-1:0] d);
    exp_t e;
    logic [DW-1:0] cap;
    logic [NW-1:0] b;
    @(negedge clk);
    cs_a_n = ca; cs_b_n = cb; ctl_odt = odt; ctl_cke = cke; d_in = d;
    if (cfg_dual) cap = {{(DW-NW){1'b0}}, (cfg_hi ? d[DW-1 -: NW] : d[NW-1:0])};
    else cap = d;
    if (!(ca && cb)) m_data = cap;
    b = cfg_dual ? m_data[NW-1:0] : '0;
    e.due = cyc + 1;
    e.tag = tag;
    e.v = {m_data, b, ca, cfg_dual & ca, odt, cfg_dual & odt, cke, cfg_dual & cke};
    sb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, outs(), e.v);
      end
    end
  end

  task automatic do_reset(input logic dual, input logic hi);
    @(negedge clk);
    #5;
    cs_a_n = 1'b1; cs_b_n = 1'b1; ctl_odt = 1'b1; ctl_cke = 1'b1; d_in = '1;
    rst_n = 1'b0;
    #1;
    check("R5 async reset", outs(), '0);
    @(posedge clk);
    #2;
    check("R5 reset over chip select", outs(), '0);
    cfg_dual = dual; cfg_hi = hi; m_data = '0;
    cs_a_n = 1'b0; cs_b_n = 1'b0; ctl_odt = 1'b0; ctl_cke = 1'b0; d_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : driver
    #3;
    check("R5 reset state", outs(), '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R9: release with zero inputs
    step("R9 quiet after release", 1'b0, 1'b0, 1'b0, 1'b0, '0);
    step("R9 quiet after release", 1'b0, 1'b0, 1'b0, 1'b0, '0);
    // R1 / R3 / R8: wide mode patterns under each enabling select combination
    for (int i = 0; i < DW; i++) step("R1 walking one", 1'b0, 1'b0, i[0], i[1], DW'(1) << i);
    step("R3 cs pattern 0/1", 1'b0, 1'b1, 1'b1, 1'b0, 22'h2AAAAA);
    step("R3 cs pattern 1/0", 1'b1, 1'b0, 1'b0, 1'b1, 22'h155555);
    step("R8 wide B bank low", 1'b0, 1'b0, 1'b1, 1'b1, '1);
    // R2 / R4: frozen data, control bits still follow
    step("R2 freeze", 1'b1, 1'b1, 1'b0, 1'b0, 22'h0F0F0F);
    step("R4 control through freeze", 1'b1, 1'b1, 1'b1, 1'b0, 22'h3C3C3C);
    step("R4 control through freeze", 1'b1, 1'b1, 1'b0, 1'b1, 22'h000001);
    step("R3 release freeze", 1'b0, 1'b1, 1'b0, 1'b0, 22'h123456);
    // R6 / R7: dual mode, lower subset
    do_reset(1'b1, 1'b0);
    step("R9 quiet after release", 1'b0, 1'b0, 1'b0, 1'b0, '0);
    step("R7 lower subset", 1'b0, 1'b0, 1'b1, 1'b0, 22'h2AA555);
    step("R6 duplicate", 1'b0, 1'b1, 1'b1, 1'b1, 22'h3FF800);
    step("R6 duplicate all ones", 1'b1, 1'b0, 1'b0, 1'b1, '1);
    step("R2 freeze dual", 1'b1, 1'b1, 1'b1, 1'b1, 22'h000123);
    for (int i = 0; i < NW; i++) step("R7 walking lower", 1'b0, 1'b0, 1'b0, i[0], DW'(1) << i);
    // R7: dual mode, upper subset
    do_reset(1'b1, 1'b1);
    step("R7 upper subset", 1'b0, 1'b0, 1'b0, 1'b1, 22'h2AA555);
    step("R7 upper ignores lower", 1'b0, 1'b0, 1'b1, 1'b0, 22'h0007FF);
    step("R2 freeze upper", 1'b1, 1'b1, 1'b0, 1'b0, 22'h3FF800);
    for (int i = 0; i < NW; i++) step("R7 walking upper", 1'b1, 1'b0, 1'b1, i[0], DW'(1) << (DW - NW + i));
    // back to wide
    do_reset(1'b0, 1'b0);
    step("R8 wide after dual", 1'b0, 1'b0, 1'b1, 1'b1, 22'h3FFFFF);
    step("R1 wide pattern", 1'b1, 1'b0, 1'b0, 1'b1, 22'h2D2D2D);
    repeat (3) @(negedge clk);
    #5;
    finish_run();
  end
endmodule